// File: doc/BRIEF.md
# Lockstep Converter Lane Deframer

This block sits behind a high-speed serial receive link layer. It cuts the wide lane word into eight 16-bit converter channels and stores each complete sample word in a sixteen-slot buffer. Several copies of the block, one per converter, can run side by side and give out the same sample index in the same clock cycle, even when their links come up at different times.

Each copy discards incoming data until channel 0 carries a fixed start code. From then on it writes one sample word per buffer slot. The master copy (instance number 0) emits a single-cycle sync pulse when it sees its own start code. A fixed delay later it begins stepping a read pointer, which it drives out. Slave copies time their reads from the master's pulse and address the buffer with the master's pointer. All copies therefore read the same slot at the same moment. A lane-mode parameter selects a four-lane input, which carries a whole sample word per clock, or a two-lane input, which takes two clocks per word.

Top module: `lane_sync_deframer`

## Requirements
- R1: `link_ready` is 1 in every cycle after reset, and `link_valid` has no effect on any output.
- R2: In four-lane mode the 128-bit input carries channel c in bits [16c+15:16c], and a new sample word is taken every clock.
- R3: In two-lane mode, the first input cycle after reset and every second cycle after it carry the low bytes of the eight channels, with channel c in bits [8c+7:8c]. The next cycle carries the high bytes in the same positions. One sample word is complete every two clocks.
- R4: The buffer write address stays 0 until a completed word has 16'hA5A5 on channel 0. That word is stored in slot 0, and each later word goes to the next slot, wrapping after slot 15.
- R5: On the master (CORE_ID = 0), `sync_out` is high for exactly one cycle, and that cycle follows the clock edge at which the start word was accepted. `raddr_out` is the master's own read address.
- R6: Reading starts so that the first `samp_valid` appears RD_DELAY+2 cycles after the cycle in which the governing sync pulse is high. After that, one sample word is given out per clock in four-lane mode and one per two clocks in two-lane mode.
- R7: A slave (CORE_ID ≠ 0) uses `sync_in` and `raddr_in` instead of its own start detection and pointer. Its `sync_out` and `raddr_out` repeat those inputs, so that further copies can be chained.
- R8: Words are given out in slot order, beginning with the start word. A master and a slave fed with the same stream give out identical data in the same cycles.
- R9: Bit c of `samp_valid` can be 1 only if bit c of `chan_en` was 1 at the clock edge that produced the output.
- R10: While `rst_n` is low, `samp_valid`, `sync_out` and the master's `raddr_out` are 0, and start detection is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every register |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_data | input | 128 (four lanes) / 64 (two lanes) | Lane word from the link layer |
| link_valid | input | 1 | Qualifier from the link layer (not used) |
| link_ready | output | 1 | Constant 1 |
| chan_en | input | 8 | Per-channel output enable |
| sync_in | input | 1 | Sync pulse from the master (used by slaves) |
| raddr_in | input | 4 | Read address from the master (used by slaves) |
| sync_out | output | 1 | Sync pulse toward slave copies |
| raddr_out | output | 4 | Read address toward slave copies |
| samp_valid | output | 8 | Per-channel sample strobe |
| samp_data | output | 128 | Eight 16-bit samples, channel c in bits [16c+15:16c] |

## Verification
The assertions assume that the start code reaches channel 0 only once before detection, or that a repeat is harmless because detection is sticky. They also assume that a slave's `sync_in` is a single-cycle pulse from a master running in the same lane mode. The stimulus drives each copy from a deterministic stream with exactly one start code. Within each master/slave pair the start codes are offset by a few words, which stays well inside the headroom the sixteen slots leave around the read delay. The slave's sync and address inputs come straight from its master's outputs.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  // Input width selection: two lanes deliver half a sample word per clock.
  typedef enum logic {
    LANES_TWO  = 1'b0,
    LANES_FOUR = 1'b1
  } lane_mode_e;
endpackage

// File: rtl/lsd_lane_split.sv
module lsd_lane_split #(
  parameter int CH_NUM = 8,
  parameter int SMP_W  = 16,
  parameter int IN_W   = 128,
  parameter bit FOUR   = 1'b1,
  localparam int BUS_W = CH_NUM * SMP_W,
  localparam int HALF  = SMP_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IN_W-1:0]  lane_data,
  output logic [BUS_W-1:0] word,
  output logic             word_vld
);
  logic [BUS_W-1:0] word_n;
  logic             vld_n;

  generate
    if (FOUR) begin : g_four
      always_comb begin
        word_n = lane_data;
        vld_n  = 1'b1;
      end
    end else begin : g_two
      logic             ph_q, ph_n;
      logic [IN_W-1:0]  lo_q, lo_n;
      logic [BUS_W-1:0] asm_word;

      for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
        assign asm_word[c*SMP_W +: SMP_W] = {lane_data[c*HALF +: HALF], lo_q[c*HALF +: HALF]};
      end

      always_comb begin
        ph_n   = ~ph_q;
        lo_n   = ph_q ? lo_q : lane_data;
        word_n = ph_q ? asm_word : word;
        vld_n  = ph_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ph_q <= 1'b0;
          lo_q <= '0;
        end else begin
          ph_q <= ph_n;
          lo_q <= lo_n;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word     <= '0;
      word_vld <= 1'b0;
    end else begin
      word     <= word_n;
      word_vld <= vld_n;
    end
  end
endmodule

// File: rtl/lsd_sync_buf.sv
module lsd_sync_buf #(
  parameter int BUS_W  = 128,
  parameter int SMP_W  = 16,
  parameter int ADDR_W = 4,
  parameter logic [SMP_W-1:0] START_CODE = 16'hA5A5,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  wr_word,
  input  logic              wr_vld,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BUS_W-1:0]  rd_word,
  output logic              start_hit,
  output logic              det,
  output logic [ADDR_W-1:0] wptr
);
  logic [BUS_W-1:0]  mem [DEPTH];
  logic              det_n, wr_en;
  logic [ADDR_W-1:0] wptr_n;

  always_comb begin
    start_hit = wr_vld && !det && (wr_word[SMP_W-1:0] == START_CODE);
    wr_en     = wr_vld && (det || start_hit);
    det_n     = det | start_hit;
    wptr_n    = wr_en ? wptr + 1'b1 : wptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det  <= 1'b0;
      wptr <= '0;
    end else begin
      det  <= det_n;
      wptr <= wptr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_word;
  end

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/lsd_rd_seq.sv
module lsd_rd_seq #(
  parameter int ADDR_W   = 4,
  parameter int RD_DELAY = 8,
  parameter bit FOUR     = 1'b1,
  localparam int DW      = $clog2(RD_DELAY + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic              fire
);
  logic [DW-1:0]     dly_q, dly_n;
  logic              run_q, run_n, ph_q, ph_n;
  logic [ADDR_W-1:0] ptr_n;

  assign fire = run_q & ph_q;

  always_comb begin
    dly_n = dly_q;
    run_n = run_q;
    ph_n  = ph_q;
    ptr_n = rd_ptr;
    if (sync) begin
      dly_n = DW'(RD_DELAY);
      run_n = 1'b0;
      ph_n  = 1'b1;
      ptr_n = '0;
    end else begin
      if (dly_q != '0) begin
        dly_n = dly_q - 1'b1;
        if (dly_q == DW'(1)) run_n = 1'b1;
      end
      if (run_q) begin
        ph_n = FOUR ? 1'b1 : ~ph_q;
        if (fire) ptr_n = rd_ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q  <= '0;
      run_q  <= 1'b0;
      ph_q   <= 1'b1;
      rd_ptr <= '0;
    end else begin
      dly_q  <= dly_n;
      run_q  <= run_n;
      ph_q   <= ph_n;
      rd_ptr <= ptr_n;
    end
  end
endmodule

// File: rtl/lane_sync_deframer.sv
module lane_sync_deframer
  import lsd_pkg::*;
#(
  parameter int          CORE_ID   = 0,
  parameter lane_mode_e  LANE_MODE = LANES_FOUR,
  parameter int          CH_NUM    = 8,
  parameter int          SMP_W     = 16,
  parameter int          ADDR_W    = 4,
  parameter int          RD_DELAY  = 8,
  parameter logic [SMP_W-1:0] START_CODE = 16'hA5A5,
  localparam int BUS_W = CH_NUM * SMP_W,
  localparam int IN_W  = (LANE_MODE == LANES_FOUR) ? BUS_W : BUS_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IN_W-1:0]   link_data,
  input  logic              link_valid,
  output logic              link_ready,
  input  logic [CH_NUM-1:0] chan_en,
  input  logic              sync_in,
  input  logic [ADDR_W-1:0] raddr_in,
  output logic              sync_out,
  output logic [ADDR_W-1:0] raddr_out,
  output logic [CH_NUM-1:0] samp_valid,
  output logic [BUS_W-1:0]  samp_data
);
  localparam bit IS_MASTER = (CORE_ID == 0);
  localparam bit FOUR      = (LANE_MODE == LANES_FOUR);

  logic [BUS_W-1:0]  word, rd_word;
  logic              word_vld, start_hit, det, rd_fire;
  logic [ADDR_W-1:0] wptr, lptr, raddr_eff;
  logic              sync_q, sync_n, sync_eff;
  logic [CH_NUM-1:0] vld_n;
  logic              link_valid_unused;

  assign link_valid_unused = link_valid;
  assign link_ready        = 1'b1;

  lsd_lane_split #(.CH_NUM(CH_NUM), .SMP_W(SMP_W), .IN_W(IN_W), .FOUR(FOUR)) u_split (
    .clk(clk), .rst_n(rst_n), .lane_data(link_data), .word(word), .word_vld(word_vld)
  );

  lsd_sync_buf #(.BUS_W(BUS_W), .SMP_W(SMP_W), .ADDR_W(ADDR_W), .START_CODE(START_CODE)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_word(word), .wr_vld(word_vld), .rd_addr(raddr_eff),
    .rd_word(rd_word), .start_hit(start_hit), .det(det), .wptr(wptr)
  );

  lsd_rd_seq #(.ADDR_W(ADDR_W), .RD_DELAY(RD_DELAY), .FOUR(FOUR)) u_seq (
    .clk(clk), .rst_n(rst_n), .sync(sync_eff), .rd_ptr(lptr), .fire(rd_fire)
  );

  always_comb begin
    sync_eff  = IS_MASTER ? sync_q : sync_in;
    raddr_eff = IS_MASTER ? lptr : raddr_in;
    sync_n    = start_hit;
    vld_n     = rd_fire ? chan_en : '0;
  end

  assign sync_out  = sync_eff;
  assign raddr_out = raddr_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= 1'b0;
      samp_valid <= '0;
    end else begin
      sync_q     <= sync_n;
      samp_valid <= vld_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       samp_data <= '0;
    else if (rd_fire) samp_data <= rd_word;
  end
endmodule

// File: rtl/lane_sync_deframer_chk.sv
module lane_sync_deframer_chk #(
  parameter bit IS_MST = 1'b1,
  parameter bit FOUR_L = 1'b1,
  parameter int CH_NUM = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              link_ready,
  input logic              sync_out,
  input logic [CH_NUM-1:0] samp_valid,
  input logic [CH_NUM-1:0] chan_en,
  input logic [ADDR_W-1:0] raddr_out,
  input logic              det,
  input logic [ADDR_W-1:0] wptr,
  input logic              rd_fire
);
  assert_ready_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    link_ready == 1'b1);

  assert_wptr_parked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !det |-> (wptr == '0));

  assert_wptr_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (FOUR_L && det) |=> (wptr == $past(wptr) + 1'b1));

  assert_sync_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_MST && sync_out) |=> !sync_out);

  assert_ptr_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_MST && rd_fire) |=> (raddr_out == $past(raddr_out) + 1'b1));

  assert_two_lane_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!FOUR_L && (|samp_valid)) |=> (samp_valid == '0));

  assert_valid_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((samp_valid & ~$past(chan_en)) == '0));
endmodule

bind lane_sync_deframer lane_sync_deframer_chk #(
  .IS_MST(IS_MASTER), .FOUR_L(FOUR), .CH_NUM(CH_NUM), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .link_ready(link_ready), .sync_out(sync_out),
  .samp_valid(samp_valid), .chan_en(chan_en), .raddr_out(raddr_out),
  .det(det), .wptr(wptr), .rd_fire(rd_fire)
);

// File: tb/lane_sync_deframer_tb.sv
module lane_sync_deframer_tb;
  import lsd_pkg::*;

  localparam int DLY     = 8;
  localparam int Q_M     = 5;   // start word index, four-lane master
  localparam int Q_S     = 8;   // four-lane slave, later
  localparam int D_M     = 6;   // two-lane master
  localparam int D_S     = 4;   // two-lane slave, earlier
  localparam int RUN_CYC = 320;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [127:0] qm_in, qs_in;
  logic [63:0]  dm_in, ds_in;
  logic         lv;
  logic [7:0]   en;

  logic         qm_rdy, qs_rdy, dm_rdy, ds_rdy;
  logic         qm_so, qs_so, dm_so, ds_so;
  logic [3:0]   qm_ra, qs_ra, dm_ra, ds_ra;
  logic [7:0]   qm_v, qs_v, dm_v, ds_v;
  logic [127:0] qm_d, qs_d, dm_d, ds_d;

  lane_sync_deframer #(.CORE_ID(0), .LANE_MODE(LANES_FOUR)) u_dut (
    .clk(clk), .rst_n(rst_n), .link_data(qm_in), .link_valid(lv), .link_ready(qm_rdy),
    .chan_en(en), .sync_in(1'b0), .raddr_in(4'h0), .sync_out(qm_so), .raddr_out(qm_ra),
    .samp_valid(qm_v), .samp_data(qm_d));
  lane_sync_deframer #(.CORE_ID(1), .LANE_MODE(LANES_FOUR)) u_dut_qs (
    .clk(clk), .rst_n(rst_n), .link_data(qs_in), .link_valid(lv), .link_ready(qs_rdy),
    .chan_en(en), .sync_in(qm_so), .raddr_in(qm_ra), .sync_out(qs_so), .raddr_out(qs_ra),
    .samp_valid(qs_v), .samp_data(qs_d));
  lane_sync_deframer #(.CORE_ID(0), .LANE_MODE(LANES_TWO)) u_dut_dm (
    .clk(clk), .rst_n(rst_n), .link_data(dm_in), .link_valid(lv), .link_ready(dm_rdy),
    .chan_en(en), .sync_in(1'b0), .raddr_in(4'h0), .sync_out(dm_so), .raddr_out(dm_ra),
    .samp_valid(dm_v), .samp_data(dm_d));
  lane_sync_deframer #(.CORE_ID(2), .LANE_MODE(LANES_TWO)) u_dut_ds (
    .clk(clk), .rst_n(rst_n), .link_data(ds_in), .link_valid(lv), .link_ready(ds_rdy),
    .chan_en(en), .sync_in(dm_so), .raddr_in(dm_ra), .sync_out(ds_so), .raddr_out(ds_ra),
    .samp_valid(ds_v), .samp_data(ds_d));

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int t_since [2] = '{-1, -1};
  int k_idx   [2] = '{0, 0};
  int n_valid [2] = '{0, 0};
  bit done = 1'b0;

  function automatic logic [15:0] samp(input int n, input int c);
    if (n == 0 && c == 0) return 16'hA5A5;
    return 16'(n * 16 + c + 'h1000);
  endfunction

  function automatic logic [127:0] exp_word(input int k);
    logic [127:0] r;
    for (int c = 0; c < 8; c++) r[c*16 +: 16] = samp(k, c);
    return r;
  endfunction

  function automatic logic [127:0] stream_word(input int w, input int s);
    logic [127:0] r;
    for (int c = 0; c < 8; c++)
      r[c*16 +: 16] = (w < s) ? 16'(16'h3000 + w * 8 + c) : samp(w - s, c);
    return r;
  endfunction

  function automatic logic [63:0] half_word(input int cy, input int s);
    logic [127:0] f;
    logic [63:0]  r;
    f = stream_word(cy / 2, s);
    for (int c = 0; c < 8; c++)
      r[c*8 +: 8] = (cy % 2 == 1) ? f[c*16+8 +: 8] : f[c*16 +: 8];
    return r;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // Behavioural model of one master/slave pair, evaluated once per clock.
  task automatic pair_chk(input int p, input logic msy, input logic ssy,
                          input logic [3:0] mra, input logic [3:0] sra,
                          input logic [7:0] mv, input logic [7:0] sv,
                          input logic [127:0] md, input logic [127:0] sd);
    bit          four = (p == 0);
    int          s    = four ? Q_M : D_M;
    int          sc   = four ? s + 2 : 2 * s + 3;
    bit          fire;
    logic [7:0]  ev;
    chk("R5", "master sync_out", 128'(msy), 128'(cyc == sc));
    chk("R7", "slave sync_out", 128'(ssy), 128'(msy));
    chk("R7", "slave raddr_out", 128'(sra), 128'(mra));
    if (msy) t_since[p] = 0;
    else if (t_since[p] >= 0) t_since[p]++;
    fire = (t_since[p] >= DLY + 2) && (four || ((t_since[p] - DLY - 2) % 2 == 0));
    ev   = fire ? en : 8'h00;
    chk("R6 R9", "master samp_valid", 128'(mv), 128'(ev));
    chk("R6 R9", "slave samp_valid", 128'(sv), 128'(ev));
    if (fire) begin
      chk(four ? "R2 R4" : "R3 R4", "master samp_data", md, exp_word(k_idx[p]));
      chk("R8", "slave samp_data", sd, exp_word(k_idx[p]));
      k_idx[p]++;
      if (en != 8'h00) n_valid[p]++;
    end
  endtask

  // Checks, then stimulus, on every falling edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      pair_chk(0, qm_so, qs_so, qm_ra, qs_ra, qm_v, qs_v, qm_d, qs_d);
      pair_chk(1, dm_so, ds_so, dm_ra, ds_ra, dm_v, ds_v, dm_d, ds_d);
      chk("R1", "link_ready", 128'({qm_rdy, qs_rdy, dm_rdy, ds_rdy}), 128'(4'hF));
    end
    qm_in = stream_word(cyc, Q_M);
    qs_in = stream_word(cyc, Q_S);
    dm_in = half_word(cyc, D_M);
    ds_in = half_word(cyc, D_S);
    lv    = 1'((cyc / 3) % 2);   // R1: toggled qualifier must not matter
    if (cyc == 150)      en = 8'h5A;  // R9: partial enable
    else if (cyc == 200) en = 8'h00;
    else if (cyc == 230) en = 8'hFF;
    if (rst_n) cyc++;
  end

  initial begin
    en = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: outputs held clear in reset
    chk("R10", "valid in reset", 128'({qm_v, qs_v, dm_v, ds_v}), 128'(0));
    chk("R10", "sync in reset", 128'({qm_so, qs_so, dm_so, ds_so}), 128'(0));
    chk("R10", "raddr in reset", 128'({qm_ra, dm_ra}), 128'(0));
    @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (RUN_CYC) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    chk("R6", "four-lane outputs seen", 128'(n_valid[0] > 100), 128'(1));
    chk("R6", "two-lane outputs seen", 128'(n_valid[1] > 50), 128'(1));
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule